// File: doc/BRIEF.md
# Latency-Timed Result Broadcast Arbiter

This block stands for the execute and write-back end of an out-of-order core. The reservation stations hand it operations. Each operation carries the tag of the station that owns it, a 3-bit operation code and two operands. The block computes a placeholder integer result when it accepts the operation. It then holds the operation for a number of cycles that depends on the operation's class.

When the count runs out, the result asks for the one shared result bus. The bus delivers a tag and a value to every waiting consumer in the same cycle. Only one result can use the bus per cycle, so results that finish together compete for it. The result that was dispatched first wins. The others keep their tag and value and wait, for as many cycles as it takes.

Each tag has one in-flight slot. A station must wait until its previous result has been broadcast before it dispatches again.

Top module: `rb_cdb_arbiter`

## Requirements
- R1: An accepted operation first appears on the bus L clock edges after the edge that accepted it, unless an older result holds the bus. L is LAT_INT (default 1) for codes 0, 5, 6 and 7, LAT_ADD (default 2) for codes 1 and 2, LAT_MUL (default 10) for code 3 and LAT_DIV (default 40) for code 4.
- R2: The broadcast value depends on the operation code:
  - 0, 6 and 7 give a+b.
  - 1 gives a+b.
  - 2 gives a-b modulo 2^DATA_W.
  - 3 gives the low DATA_W bits of a*b.
  - 4 gives the unsigned quotient a/b, or all ones when b is zero.
  - 5 passes a through.
- R3: Every broadcast carries the tag given with the operation that produced it.
- R4: The bus carries at most one result per cycle.
- R5: When several results are ready, the one accepted earliest is broadcast first. A slot that becomes ready later but was dispatched earlier beats a younger result that is already waiting.
- R6: A result that loses arbitration is never dropped. It is broadcast later with its original tag and value.
- R7: A dispatch whose tag already has an operation in flight is ignored. The in-flight operation keeps its value and timing, and no second broadcast appears.
- R8: While the synchronous reset is high, all in-flight operations are discarded and the bus is idle. Nothing is broadcast after reset until a new dispatch arrives.
- R9: When cdb_valid is low, cdb_tag and cdb_value are zero.
- R10: A tag can be dispatched again in the cycle in which its previous result is on the bus. That dispatch is accepted.
- R11: If any result is ready at a clock edge, a result is broadcast after that edge. The bus never idles while results wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | A dispatch is presented this cycle |
| disp_tag | input | TAG_W | Tag of the issuing reservation station |
| disp_op | input | 3 | Operation code (see R1, R2) |
| disp_a | input | DATA_W | First operand |
| disp_b | input | DATA_W | Second operand |
| cdb_valid | output | 1 | A result is broadcast this cycle |
| cdb_tag | output | TAG_W | Tag of the producing station |
| cdb_value | output | DATA_W | Broadcast result value |

## Verification
The hardest case to reach from the ports is a slot that becomes ready in the same cycle as another, or after another has already started waiting. The age order must then decide the winner, and lowest-tag order must not. The stimulus creates this by working backwards from the fixed latencies. It dispatches a long multiply, then a short add a few cycles later, then an integer operation on the lowest tag. The offsets are chosen so that all three finish at the same edge, and the broadcast order must follow dispatch order. A second scenario makes an older multiply become ready one cycle after a younger integer result has begun waiting. The bench also checks that the waiting result comes out intact afterwards.

// File: rtl/rb_pkg.sv
package rb_pkg;
   typedef enum logic [2:0] {
      OP_INT  = 3'd0,
      OP_ADD  = 3'd1,
      OP_SUB  = 3'd2,
      OP_MUL  = 3'd3,
      OP_DIV  = 3'd4,
      OP_LOAD = 3'd5
   } rb_op_e;

   typedef enum logic [1:0] {
      CLS_SHORT = 2'd0,
      CLS_ADD   = 2'd1,
      CLS_MUL   = 2'd2,
      CLS_DIV   = 2'd3
   } rb_cls_e;

   function automatic rb_cls_e op_class(input logic [2:0] op);
      case (op)
         OP_ADD, OP_SUB: op_class = CLS_ADD;
         OP_MUL:         op_class = CLS_MUL;
         OP_DIV:         op_class = CLS_DIV;
         default:        op_class = CLS_SHORT;
      endcase
   endfunction
endpackage

// File: rtl/rb_exec.sv
module rb_exec
   import rb_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 6,
   parameter int LAT_INT = 1,
   parameter int LAT_ADD = 2,
   parameter int LAT_MUL = 10,
   parameter int LAT_DIV = 40
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] result,
   output logic [CNT_W-1:0]  wait_cycles
);
   // Result is formed once at dispatch; slots only hold it.
   always_comb begin
      case (op)
         OP_SUB:  result = a - b;
         OP_MUL:  result = a * b;
         OP_DIV:  result = (b == '0) ? '1 : a / b;
         OP_LOAD: result = a;
         default: result = a + b;
      endcase
   end

   // Remaining cycles after the accepting edge before the slot is ready.
   always_comb begin
      case (op_class(op))
         CLS_ADD: wait_cycles = CNT_W'(LAT_ADD - 1);
         CLS_MUL: wait_cycles = CNT_W'(LAT_MUL - 1);
         CLS_DIV: wait_cycles = CNT_W'(LAT_DIV - 1);
         default: wait_cycles = CNT_W'(LAT_INT - 1);
      endcase
   end
endmodule

// File: rtl/rb_slot.sv
module rb_slot #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_wait,
   input  logic [DATA_W-1:0] load_value,
   input  logic              grant,
   output logic              busy,
   output logic              ready,
   output logic [DATA_W-1:0] value
);
   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy   <= 1'b0;
         remain <= '0;
         value  <= '0;
      end else if (load) begin
         busy   <= 1'b1;
         remain <= load_wait;
         value  <= load_value;
      end else if (grant) begin
         busy   <= 1'b0;
      end else if (busy && remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign ready = busy && (remain == '0);

   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
      (busy && remain != '0 && !load) |=> (busy && remain == $past(remain) - 1'b1)) // R1
      else $error("slot countdown broken");

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (ready && !grant && !load) |=> (ready && $stable(value))) // R6
      else $error("stalled result lost");

   AST_GRANT_READY: assert property (@(posedge clk) disable iff (rst)
      grant |-> ready) // R6
      else $error("grant to unready slot");
endmodule

// File: rtl/rb_age_arb.sv
module rb_age_arb #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] alloc,
   input  logic [N-1:0] busy,
   input  logic [N-1:0] ready,
   output logic [N-1:0] grant
);
   // older_than[i][j] set: slot j was accepted before slot i.
   logic [N-1:0] older_than [N];
   logic [N-1:0] cand;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < N; i++) older_than[i] <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
               if (alloc[i])
                  older_than[i][j] <= busy[j] & ~grant[j];
               else if (alloc[j])
                  older_than[i][j] <= 1'b0;
            end
         end
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_cand
      assign cand[g] = ready[g] && ((older_than[g] & ready) == '0);
   end

   // Age order is total among busy slots; lowest index settles any tie.
   always_comb begin
      grant = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cand[i]) grant = N'(1) << i;
      end
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant)) // R4
      else $error("multiple grants");

   AST_NO_IDLE: assert property (@(posedge clk) disable iff (rst)
      (ready != '0) |-> (grant != '0)) // R11
      else $error("bus idle with ready result");
endmodule

// File: rtl/rb_cdb_arbiter.sv
module rb_cdb_arbiter
   import rb_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NUM_TAGS = 8,
   parameter int LAT_INT  = 1,
   parameter int LAT_ADD  = 2,
   parameter int LAT_MUL  = 10,
   parameter int LAT_DIV  = 40,
   localparam int TAG_W   = $clog2(NUM_TAGS),
   localparam int LAT_MAX = (LAT_DIV > LAT_MUL) ? LAT_DIV : LAT_MUL,
   localparam int CNT_W   = $clog2(LAT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              disp_valid,
   input  logic [TAG_W-1:0]  disp_tag,
   input  logic [2:0]        disp_op,
   input  logic [DATA_W-1:0] disp_a,
   input  logic [DATA_W-1:0] disp_b,
   output logic              cdb_valid,
   output logic [TAG_W-1:0]  cdb_tag,
   output logic [DATA_W-1:0] cdb_value
);
   if (NUM_TAGS < 2) begin : g_bad_tags
      $error("NUM_TAGS must be at least 2");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8");
   end
   if (LAT_INT < 1 || LAT_ADD < 1 || LAT_MUL < 1 || LAT_DIV < 1) begin : g_bad_lat
      $error("every latency must be at least 1");
   end

   logic [DATA_W-1:0] exec_result;
   logic [CNT_W-1:0]  exec_wait;
   logic [NUM_TAGS-1:0] busy, ready, grant, alloc;
   logic [DATA_W-1:0] slot_value [NUM_TAGS];
   logic              accept;
   logic [TAG_W-1:0]  win_tag;
   logic [DATA_W-1:0] win_value;

   rb_exec #(
      .DATA_W (DATA_W), .CNT_W (CNT_W),
      .LAT_INT(LAT_INT), .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
   ) u_exec (
      .op(disp_op), .a(disp_a), .b(disp_b),
      .result(exec_result), .wait_cycles(exec_wait)
   );

   assign accept = disp_valid && (int'(disp_tag) < NUM_TAGS) && !busy[disp_tag];

   for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
      assign alloc[g] = accept && (int'(disp_tag) == g);
      rb_slot #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_slot (
         .clk(clk), .rst(rst),
         .load(alloc[g]), .load_wait(exec_wait), .load_value(exec_result),
         .grant(grant[g]),
         .busy(busy[g]), .ready(ready[g]), .value(slot_value[g])
      );
   end

   rb_age_arb #(.N(NUM_TAGS)) u_arb (
      .clk(clk), .rst(rst), .alloc(alloc), .busy(busy), .ready(ready), .grant(grant)
   );

   always_comb begin
      win_tag   = '0;
      win_value = '0;
      for (int i = 0; i < NUM_TAGS; i++) begin
         if (grant[i]) begin
            win_tag   = TAG_W'(i);
            win_value = slot_value[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cdb_valid <= 1'b0;
         cdb_tag   <= '0;
         cdb_value <= '0;
      end else begin
         cdb_valid <= grant != '0;
         cdb_tag   <= win_tag;
         cdb_value <= win_value;
      end
   end

   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (!cdb_valid && busy == '0)) // R8
      else $error("reset left state");

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !cdb_valid |-> (cdb_tag == '0 && cdb_value == '0)) // R9
      else $error("idle bus not zero");

   AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (rst)
      (disp_valid && busy[disp_tag] && !grant[disp_tag]) |=> busy[$past(disp_tag)]) // R7
      else $error("dispatch to busy tag disturbed slot");
endmodule

// File: tb/tb_rb_cdb_arbiter.sv
module tb_rb_cdb_arbiter;
   localparam int DW = 32;
   localparam int TW = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          disp_valid = 1'b0;
   logic [TW-1:0] disp_tag = '0;
   logic [2:0]    disp_op = '0;
   logic [DW-1:0] disp_a = '0, disp_b = '0;
   logic          cdb_valid;
   logic [TW-1:0] cdb_tag;
   logic [DW-1:0] cdb_value;

   int n_tests = 0, n_fail = 0, cyc = 0, idle_bad = 0;
   int n_log = 0;
   int          log_cyc [64];
   logic [TW-1:0] log_tag [64];
   logic [DW-1:0] log_val [64];

   rb_cdb_arbiter dut (
      .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_tag(disp_tag),
      .disp_op(disp_op), .disp_a(disp_a), .disp_b(disp_b),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (cdb_valid && n_log < 64) begin
         log_cyc[n_log] = cyc;
         log_tag[n_log] = cdb_tag;
         log_val[n_log] = cdb_value;
         n_log++;
      end
      if (!rst && !cdb_valid && (cdb_tag != '0 || cdb_value != '0)) idle_bad++;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_log();
      n_log = 0;
   endtask

   // Presents one dispatch at a negedge; returns the cycle number of the accepting edge.
   task automatic dispatch(input logic [TW-1:0] t, input logic [2:0] op,
                           input logic [DW-1:0] a, input logic [DW-1:0] b, output int at);
      disp_valid = 1'b1; disp_tag = t; disp_op = op; disp_a = a; disp_b = b;
      @(posedge clk);
      @(negedge clk);
      at = cyc;
      disp_valid = 1'b0;
   endtask

   task automatic expect_entry(input int k, input string req, input int c,
                               input logic [TW-1:0] t, input logic [DW-1:0] v);
      chk({req, " cycle"}, 64'(log_cyc[k]), 64'(c));
      chk({req, " tag"},   64'(log_tag[k]), 64'(t));
      chk({req, " value"}, 64'(log_val[k]), 64'(v));
   endtask

   task automatic t_reset();
      chk("R8 reset valid", 64'(cdb_valid), 64'd0);
      chk("R9 reset tag",   64'(cdb_tag), 64'd0);
      chk("R9 reset value", 64'(cdb_value), 64'd0);
   endtask

   // R1 R2 R3: a lone operation per code
   task automatic t_single(input logic [2:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b,
                           input logic [TW-1:0] t, input logic [DW-1:0] v, input int lat);
      int at;
      clear_log();
      dispatch(t, op, a, b, at);
      idle(lat + 3);
      chk("R1 single count", 64'(n_log), 64'd1);
      expect_entry(0, "R1 R2 R3 single", at + lat, t, v);
   endtask

   // R5 R6 R4: three results ready at the same edge
   task automatic t_same_edge();
      int a0, a1, a2;
      clear_log();
      dispatch(3'd5, 3'd3, 32'd6, 32'd7, a0);
      idle(7);
      dispatch(3'd2, 3'd1, 32'd10, 32'd20, a1);
      dispatch(3'd0, 3'd0, 32'd1, 32'd1, a2);
      idle(8);
      chk("R4 same-edge count", 64'(n_log), 64'd3);
      expect_entry(0, "R5 oldest first", a0 + 10, 3'd5, 32'd42);
      expect_entry(1, "R6 second waits", a0 + 11, 3'd2, 32'd30);
      expect_entry(2, "R6 lowest tag youngest", a0 + 12, 3'd0, 32'd2);
   endtask

   // R5 R11: older slot becomes ready after a younger one already waits
   task automatic t_late_older();
      int a0, a1, a2;
      clear_log();
      dispatch(3'd3, 3'd3, 32'd3, 32'd3, a0);
      dispatch(3'd1, 3'd3, 32'd4, 32'd4, a1);
      idle(7);
      dispatch(3'd4, 3'd5, 32'd77, 32'd0, a2);
      idle(8);
      chk("R5 late-older count", 64'(n_log), 64'd3);
      expect_entry(0, "R11 first", a0 + 10, 3'd3, 32'd9);
      expect_entry(1, "R5 older beats waiting", a0 + 11, 3'd1, 32'd16);
      expect_entry(2, "R6 waiter later", a0 + 12, 3'd4, 32'd77);
   endtask

   // R7: second dispatch to an in-flight tag has no effect
   task automatic t_busy_ignore();
      int a0, a1;
      clear_log();
      dispatch(3'd6, 3'd4, 32'd50, 32'd5, a0);
      dispatch(3'd6, 3'd0, 32'd9, 32'd9, a1);
      idle(44);
      chk("R7 one broadcast", 64'(n_log), 64'd1);
      expect_entry(0, "R7 kept", a0 + 40, 3'd6, 32'd10);
   endtask

   // R10: re-dispatch in the cycle the previous result is on the bus
   task automatic t_redispatch();
      int a0, a1;
      clear_log();
      dispatch(3'd2, 3'd0, 32'd1, 32'd2, a0);
      chk("R10 bus busy now", 64'(cdb_valid), 64'd0);
      idle(1);
      chk("R10 prior on bus", 64'(cdb_valid), 64'd1);
      dispatch(3'd2, 3'd0, 32'd5, 32'd5, a1);
      idle(3);
      chk("R10 count", 64'(n_log), 64'd2);
      expect_entry(1, "R10 accepted", a1 + 1, 3'd2, 32'd10);
   endtask

   // R8: reset in flight discards work
   task automatic t_reset_flight();
      int a0;
      clear_log();
      dispatch(3'd7, 3'd3, 32'd2, 32'd2, a0);
      idle(3);
      rst = 1'b1;
      idle(1);
      rst = 1'b0;
      idle(15);
      chk("R8 flushed", 64'(n_log), 64'd0);
   endtask

   initial begin
      idle(3);
      t_reset();
      rst = 1'b0;
      idle(1);
      t_single(3'd0, 32'd5, 32'd7, 3'd1, 32'd12, 1);
      t_single(3'd1, 32'd100, 32'd23, 3'd7, 32'd123, 2);
      t_single(3'd2, 32'd3, 32'd10, 3'd4, 32'hFFFF_FFF9, 2);
      t_single(3'd3, 32'd1234, 32'd5678, 3'd0, 32'd7006652, 10);
      t_single(3'd4, 32'd100, 32'd7, 3'd3, 32'd14, 40);
      t_single(3'd4, 32'd100, 32'd0, 3'd3, 32'hFFFF_FFFF, 40);
      t_single(3'd5, 32'hCAFE, 32'd1, 3'd6, 32'hCAFE, 1);
      t_single(3'd6, 32'd8, 32'd9, 3'd5, 32'd17, 1);
      t_same_edge();
      t_late_older();
      t_busy_ignore();
      t_redispatch();
      t_reset_flight();
      chk("R9 idle bus zero", 64'(idle_bad), 64'd0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule